// File: doc/BRIEF.md
# Descriptor-Driven Periodic Word Scheduler

This block produces a repeating burst of 32-bit serial-bus words from a table of descriptors held in local RAM. A descriptor is four slots, one per byte of the outgoing word, and every slot is an action byte followed by a value byte. The top three bits of the action byte are an op-code that says where the byte comes from. It can be the value byte itself, the value byte with its bit order reversed, or a byte of a received-data block picked by channel, label and byte select. Two further kinds of op-code end the whole pass or drop the word being built. The block reads the RAM one byte at a time through a read port with one cycle of latency. It hands each complete word to a transmitter over a valid/ready handshake, and a stalled transmitter freezes the table walk.

A programmable repetition counter paces the passes through the table. A pass starts when the counter rolls over. If a pass is still running when a rollover happens, the skip input decides what follows the end of that pass. With skip set, the block waits for the next rollover. With skip clear, it starts again at once. The run input and the master transmit enable must both be high for the block to operate. When either is low, the block is held in its reset state, the counter is cleared and the table pointer returns to the first descriptor. The table and the repetition limit are written before run is raised.

Top module: `desc_tx_sched`

## Requirements
- R1: While `rst` is high, and from the clock after `tx_en` or `run` is sampled low, `word_valid`, `mem_rd_en` and `blk_clr` are 0.
- R2: Descriptor d sits at `TBL_BASE + 8*d`. Slot k (0..3) has its action byte at offset 2k and its value byte at 2k+1. Slot k supplies `word_data[8k+7:8k]`, and words leave in descriptor order.
- R3: Action op-code (bits 7:5) 010 copies the value byte. Op-code 100 copies the value byte with bit 0 and bit 7 swapped, bit 1 and bit 6 swapped, and so on.
- R4: Op-code 011 reads the byte at `DATA_BASE + {chan, label, sel}`, where chan is action bits 4:2, sel is action bits 1:0 and label is the value byte. In the cycle of that read, `blk_clr` is 1 and `blk_idx = {chan, label}`. `blk_clr` is 0 for every other read.
- R5: Op-code 000 ends the pass at once, and the word being built is dropped. A pass also ends after descriptor `NDESC-1`. Each pass emits exactly the words its table yields.
- R6: Op-codes 001, 101, 110 and 111 drop the word being built, and the walk moves on to the next descriptor.
- R7: While `word_valid` is 1 and `word_ready` is 0, `word_valid` stays 1, `word_data` holds its value and `mem_rd_en` stays 0.
- R8: While active, the counter rolls over once every `rate_limit+1` clocks, with the first rollover `rate_limit+1` clocks after activation. An idle block starts a pass on a rollover, and the first read of a pass is at `TBL_BASE`.
- R9: With `skip`=1, every pass starts on a rollover, even when the previous pass overran one.
- R10: With `skip`=0, a rollover that falls during a pass makes the next pass begin with a read of `TBL_BASE` in the cycle after the pass ends.
- R11: A drop of `run` clears the pass in progress. After `run` returns, the first read is at `TBL_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Master transmit enable |
| run | input | 1 | Scheduler run/stop |
| skip | input | 1 | Overrun policy: 1 waits for the next rollover |
| rate_limit | input | RATE_W | Repetition period minus one, in clocks |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_rd_addr | output | AW | RAM read address |
| mem_rd_data | input | 8 | RAM read data, one cycle after the strobe |
| word_valid | output | 1 | Word available to the transmitter |
| word_ready | input | 1 | Transmitter accepts the word |
| word_data | output | 32 | Assembled word |
| blk_clr | output | 1 | Pulse: a received-data block is being read |
| blk_idx | output | 11 | {channel, label} of that block |

## Verification
The bench builds the block with an eight-entry table and a 10-bit repetition counter. With these values a walk through all eight descriptors takes longer than a 50-clock period, so overruns under both skip settings and the end of a pass at the last descriptor happen within a few hundred clocks. The 200- and 300-clock periods in the other tests let random tables finish well inside a period. Random ready gaps give long stalls, and stopping the block partway through a pass shows that the pointer returns to descriptor 0.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOTS  = 4;
  localparam int WORD_W = BYTE_W * SLOTS;
  localparam int CH_W   = 3;
  localparam int SEL_W  = 2;
  localparam int LBL_W  = 8;
  localparam int BLK_W  = CH_W + LBL_W;

  localparam logic [2:0] OP_END  = 3'b000;
  localparam logic [2:0] OP_NOP  = 3'b001;
  localparam logic [2:0] OP_LIT  = 3'b010;
  localparam logic [2:0] OP_DATA = 3'b011;
  localparam logic [2:0] OP_REV  = 3'b100;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_CAP, ST_SEND} st_t;
  typedef enum logic [1:0] {PH_ACT, PH_VAL, PH_DAT} ph_t;

  typedef struct packed {
    logic [2:0]       op;
    logic [CH_W-1:0]  chan;
    logic [SEL_W-1:0] sel;
  } act_t;

  // op-codes that discard the word under construction
  function automatic logic op_drops(input logic [2:0] op);
    return (op == OP_NOP) || (op > OP_REV);
  endfunction
endpackage

// File: rtl/sched_rate_timer.sv
`timescale 1ns/1ps
module sched_rate_timer #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [RATE_W-1:0] limit,
  output logic              roll
);
  logic [RATE_W-1:0] cnt_q;

  assign roll = active && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !active || roll) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sched_addr_gen.sv
`timescale 1ns/1ps
module sched_addr_gen
  import sched_pkg::*;
#(
  parameter int AW        = 16,
  parameter int IDX_W     = 6,
  parameter int TBL_BASE  = 'h4000,
  parameter int DATA_BASE = 0
) (
  input  ph_t              phase,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       slot,
  input  act_t             act,
  input  logic [LBL_W-1:0] lbl,
  output logic [AW-1:0]    addr,
  output logic [BLK_W-1:0] blk
);
  localparam int OFS_W = IDX_W + 3;
  logic [OFS_W-1:0] tbl_ofs;

  always_comb begin
    blk     = {act.chan, lbl};
    tbl_ofs = {idx, slot, (phase == PH_VAL)};
    if (phase == PH_DAT) addr = AW'(DATA_BASE) + AW'({blk, act.sel});
    else                 addr = AW'(TBL_BASE) + AW'(tbl_ofs);
  end
endmodule

// File: rtl/sched_byte_former.sv
`timescale 1ns/1ps
module sched_byte_former
  import sched_pkg::*;
(
  input  logic [2:0]        op,
  input  logic              from_data,
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] rev;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
    assign rev[b] = raw[BYTE_W-1-b];
  end

  assign byte_o = (!from_data && op == OP_REV) ? rev : raw;
endmodule

// File: rtl/desc_tx_sched.sv
`timescale 1ns/1ps
module desc_tx_sched
  import sched_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NDESC     = 64,
  parameter int RATE_W    = 16,
  parameter int TBL_BASE  = 'h4000,
  parameter int DATA_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              run,
  input  logic              skip,
  input  logic [RATE_W-1:0] rate_limit,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [31:0]       word_data,
  output logic              blk_clr,
  output logic [10:0]       blk_idx
);
  localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDESC - 1);

  st_t                st_q, nxt_st;
  ph_t                ph_q, nxt_ph;
  logic [IDX_W-1:0]   idx_q, nxt_idx;
  logic [1:0]         slot_q, nxt_slot;
  act_t               act_q, nxt_act;
  logic [LBL_W-1:0]   lbl_q, nxt_lbl;
  logic [WORD_W-1:0]  asm_q, nxt_asm;
  logic               pend_q, nxt_pend;

  logic               active, roll, restart;
  logic               do_store, do_next, do_end;
  logic [2:0]         op_in;
  logic [BYTE_W-1:0]  byte_v;
  logic [BLK_W-1:0]   blk;

  assign active  = tx_en && run;
  assign op_in   = mem_rd_data[7:5];
  assign restart = skip ? roll : (pend_q || roll);

  sched_rate_timer #(.RATE_W(RATE_W)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .active(active),
    .limit (rate_limit),
    .roll  (roll)
  );

  sched_addr_gen #(
    .AW(AW), .IDX_W(IDX_W), .TBL_BASE(TBL_BASE), .DATA_BASE(DATA_BASE)
  ) u_addr (
    .phase(ph_q),
    .idx  (idx_q),
    .slot (slot_q),
    .act  (act_q),
    .lbl  (lbl_q),
    .addr (mem_rd_addr),
    .blk  (blk)
  );

  sched_byte_former u_form (
    .op       (act_q.op),
    .from_data(ph_q == PH_DAT),
    .raw      (mem_rd_data),
    .byte_o   (byte_v)
  );

  always_comb begin
    nxt_st   = st_q;
    nxt_ph   = ph_q;
    nxt_idx  = idx_q;
    nxt_slot = slot_q;
    nxt_act  = act_q;
    nxt_lbl  = lbl_q;
    nxt_asm  = asm_q;
    nxt_pend = pend_q || roll;
    do_store = 1'b0;
    do_next  = 1'b0;
    do_end   = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        nxt_pend = 1'b0;
        if (roll) begin
          nxt_st   = ST_REQ;
          nxt_ph   = PH_ACT;
          nxt_idx  = '0;
          nxt_slot = '0;
        end
      end
      ST_REQ: nxt_st = ST_CAP;
      ST_CAP: begin
        unique case (ph_q)
          PH_ACT: begin
            nxt_act = act_t'(mem_rd_data);
            if (op_in == OP_END)     do_end  = 1'b1;
            else if (op_drops(op_in)) do_next = 1'b1;
            else begin
              nxt_ph = PH_VAL;
              nxt_st = ST_REQ;
            end
          end
          PH_VAL: begin
            nxt_lbl = mem_rd_data;
            if (act_q.op == OP_DATA) begin
              nxt_ph = PH_DAT;
              nxt_st = ST_REQ;
            end else begin
              do_store = 1'b1;
            end
          end
          default: do_store = 1'b1;
        endcase
      end
      default: begin
        if (word_ready) do_next = 1'b1;
      end
    endcase

    if (do_store) begin
      nxt_asm[{slot_q, 3'b000} +: BYTE_W] = byte_v;
      if (slot_q == 2'd3) begin
        nxt_st = ST_SEND;
      end else begin
        nxt_slot = slot_q + 2'd1;
        nxt_ph   = PH_ACT;
        nxt_st   = ST_REQ;
      end
    end

    if (do_next) begin
      if (idx_q == LAST_IDX) begin
        do_end = 1'b1;
      end else begin
        nxt_idx  = idx_q + 1'b1;
        nxt_slot = '0;
        nxt_ph   = PH_ACT;
        nxt_st   = ST_REQ;
      end
    end

    if (do_end) begin
      nxt_pend = 1'b0;
      nxt_idx  = '0;
      nxt_slot = '0;
      nxt_ph   = PH_ACT;
      nxt_st   = restart ? ST_REQ : ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ACT;
      idx_q  <= '0;
      slot_q <= '0;
      act_q  <= '0;
      lbl_q  <= '0;
      asm_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= nxt_st;
      ph_q   <= nxt_ph;
      idx_q  <= nxt_idx;
      slot_q <= nxt_slot;
      act_q  <= nxt_act;
      lbl_q  <= nxt_lbl;
      asm_q  <= nxt_asm;
      pend_q <= nxt_pend;
    end
  end

  assign mem_rd_en  = (st_q == ST_REQ);
  assign blk_clr    = mem_rd_en && (ph_q == PH_DAT);
  assign blk_idx    = blk;
  assign word_valid = (st_q == ST_SEND);
  assign word_data  = asm_q;
endmodule

// File: rtl/sched_chk.sv
`timescale 1ns/1ps
module sched_chk #(
  parameter int AW        = 16,
  parameter int NDESC     = 64,
  parameter int TBL_BASE  = 'h4000,
  parameter int DATA_BASE = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_en,
  input logic          run,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          word_valid,
  input logic          word_ready,
  input logic [31:0]   word_data,
  input logic          blk_clr,
  input logic [10:0]   blk_idx
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!word_valid && !mem_rd_en));

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && run) |=> (!word_valid && !mem_rd_en && !blk_clr));

  assert_hold_word_R7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready && tx_en && run) |=> (word_valid && $stable(word_data)));

  assert_no_read_while_offering_R7: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> !mem_rd_en);

  assert_block_addr_R4: assert property (@(posedge clk) disable iff (rst)
    blk_clr |-> (mem_rd_en && (((mem_rd_addr - AW'(DATA_BASE)) >> 2) == AW'(blk_idx))));

  assert_table_range_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !blk_clr) |->
      (mem_rd_addr >= AW'(TBL_BASE) && mem_rd_addr < AW'(TBL_BASE + 8*NDESC)));
endmodule

bind desc_tx_sched sched_chk #(
  .AW(AW), .NDESC(NDESC), .TBL_BASE(TBL_BASE), .DATA_BASE(DATA_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .run        (run),
  .mem_rd_en  (mem_rd_en),
  .mem_rd_addr(mem_rd_addr),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .word_data  (word_data),
  .blk_clr    (blk_clr),
  .blk_idx    (blk_idx)
);

// File: tb/tb_desc_tx_sched.sv
`timescale 1ns/1ps
module tb_desc_tx_sched;
  localparam int AW = 16, NDESC = 8, RATE_W = 10;
  localparam int TBL_BASE = 'h4000, DATA_BASE = 0;
  localparam int TBL_BYTES = 8 * NDESC;

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, run = 1'b0, skip = 1'b0, word_ready = 1'b0;
  logic [RATE_W-1:0] rate_limit = '0;
  logic mem_rd_en, word_valid, blk_clr;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0;
  logic [31:0] word_data;
  logic [10:0] blk_idx;

  int n_chk = 0, n_fail = 0, tick = 0, period = 1, ready_pct = 100, starts = 0;
  bit mon_on = 0, align_chk = 0, b2b_chk = 0, end_prev = 0, stall_prev = 0, off_prev = 1, first_rd = 1;
  logic [31:0] stall_data;
  logic [7:0] tbl [TBL_BYTES];
  logic [31:0] exp_q [$];

  always #2.5 clk = ~clk;

  desc_tx_sched #(.AW(AW), .NDESC(NDESC), .RATE_W(RATE_W),
                  .TBL_BASE(TBL_BASE), .DATA_BASE(DATA_BASE)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .run(run), .skip(skip), .rate_limit(rate_limit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .blk_clr(blk_clr), .blk_idx(blk_idx));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] data_fn(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'd29 + 16'h5A;
    return t[7:0] ^ t[15:8];
  endfunction

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    if (int'(a) >= TBL_BASE && int'(a) < TBL_BASE + TBL_BYTES) return tbl[int'(a) - TBL_BASE];
    return data_fn(a);
  endfunction

  // expected words for one pass, built from the requirements
  function automatic void push_cycle();
    for (int d = 0; d < NDESC; d++) begin
      logic [31:0] w;
      bit drop;
      w = '0;
      drop = 0;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a, v, b;
        a = tbl[d*8 + 2*k];
        v = tbl[d*8 + 2*k + 1];
        if (a[7:5] == 3'b000) return;
        if (a[7:5] == 3'b001 || a[7:5] >= 3'b101) begin drop = 1; break; end
        if (a[7:5] == 3'b011)      b = data_fn(16'(DATA_BASE) + 16'({a[4:2], v, a[1:0]}));
        else if (a[7:5] == 3'b100) b = rev8(v);
        else                       b = v;
        w[8*k +: 8] = b;
      end
      if (!drop) exp_q.push_back(w);
    end
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= rd_fn(mem_rd_addr);
  always @(posedge clk) tick <= (run && tx_en) ? tick + 1 : 0;
  initial forever begin
    @(posedge clk); #1;
    word_ready = ($urandom_range(0, 99) < ready_pct);
  end

  always @(negedge clk) begin
    if (mon_on) begin
      bit off, start_now, hs_last;
      off = !(run && tx_en);
      start_now = 0;
      hs_last = 0;
      if (off && off_prev)
        check(!word_valid && !mem_rd_en && !blk_clr, "R1/R11", "idle while stopped",
              {29'b0, word_valid, mem_rd_en, blk_clr}, 32'h0);
      if (off) begin
        exp_q.delete();
        first_rd = 1;
        stall_prev = 0;
        end_prev = 0;
      end else begin
        if (stall_prev)
          check(word_valid && word_data == stall_data && !mem_rd_en, "R7", "stalled word held",
                word_data, stall_data);
        if (mem_rd_en && first_rd) begin
          check(int'(mem_rd_addr) == TBL_BASE, "R11", "first read after start", 32'(mem_rd_addr), 32'(TBL_BASE));
          first_rd = 0;
        end
        if (mem_rd_en || blk_clr) begin
          bit in_data;
          in_data = int'(mem_rd_addr) < TBL_BASE;
          check(blk_clr == (mem_rd_en && in_data), "R4", "block-read strobe", 32'(blk_clr), 32'(in_data));
          if (blk_clr)
            check(blk_idx == mem_rd_addr[12:2], "R4", "block index", 32'(blk_idx), 32'(mem_rd_addr[12:2]));
        end
        if (mem_rd_en && int'(mem_rd_addr) == TBL_BASE) begin
          start_now = 1;
          starts++;
          check(exp_q.size() == 0, "R5", "words left over at pass start", exp_q.size(), 0);
          if (align_chk)
            check(tick % period == 0, "R8/R9", "pass start on rollover", tick, (tick / period) * period);
          push_cycle();
        end
        if (b2b_chk && end_prev)
          check(start_now, "R10", "immediate restart after overrun", 32'(start_now), 32'd1);
        if (word_valid && word_ready) begin
          if (exp_q.size() == 0) check(0, "R5", "unexpected extra word", word_data, 32'h0);
          else begin
            check(word_data == exp_q[0], "R2/R3/R4/R6", "word content", word_data, exp_q[0]);
            void'(exp_q.pop_front());
            hs_last = (exp_q.size() == 0);
          end
        end
        end_prev = hs_last;
        stall_prev = word_valid && !word_ready;
        stall_data = word_data;
      end
      off_prev = off;
    end
  end

  task automatic set_mode(input bit r, input bit t, input bit s, input int lim);
    @(posedge clk); #1;
    run = r; tx_en = t; skip = s;
    rate_limit = RATE_W'(lim);
    period = lim + 1;
  endtask

  task automatic fill_lit();
    for (int i = 0; i < TBL_BYTES; i += 2) begin
      tbl[i] = 8'h40 | 8'($urandom_range(0, 31));
      tbl[i+1] = 8'($urandom_range(0, 255));
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < TBL_BYTES; i += 2) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      if (r < 3)       op = 3'b000;
      else if (r < 10) op = (r % 4 == 0) ? 3'b001 : 3'(4 + r % 4);
      else if (r < 45) op = 3'b010;
      else if (r < 75) op = 3'b011;
      else             op = 3'b100;
      tbl[i] = {op, 5'($urandom_range(0, 31))};
      tbl[i+1] = 8'($urandom_range(0, 255));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    fill_lit();
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!word_valid && !mem_rd_en && !blk_clr, "R1", "reset state",
          {29'b0, word_valid, mem_rd_en, blk_clr}, 32'h0);
    mon_on = 1;

    // directed table: literal, reversed, data, dropped words, end marker
    tbl = '{8'h40,8'h11, 8'h40,8'h22, 8'h80,8'h01, 8'h40,8'h44,
            8'h76,8'h3C, 8'h40,8'hAA, 8'h60,8'hFF, 8'h40,8'h00,
            8'h40,8'h55, 8'hA0,8'h00, 8'h40,8'h01, 8'h40,8'h02,
            8'h40,8'h77, 8'h40,8'h77, 8'h40,8'h77, 8'h40,8'h77,
            8'h40,8'h12, 8'h00,8'h00, 8'h40,8'h03, 8'h40,8'h04,
            8'h40,8'h99, 8'h40,8'h99, 8'h40,8'h99, 8'h40,8'h99,
            8'h20,8'h00, 8'h40,8'h01, 8'h40,8'h02, 8'h40,8'h03,
            8'hE0,8'h00, 8'h40,8'h01, 8'h40,8'h02, 8'h40,8'h03};
    push_cycle();
    check(exp_q.size() == 3 && exp_q[0] == 32'h44802211, "R3", "bench model of directed table",
          exp_q[0], 32'h44802211);
    exp_q.delete();
    align_chk = 1;
    starts = 0;
    set_mode(1, 1, 1, 199);
    repeat (700) @(posedge clk);
    check(starts >= 3, "R8", "passes started", starts, 3);
    set_mode(0, 1, 1, 199);
    repeat (4) @(posedge clk);

    // random tables, random back-pressure
    ready_pct = 75;
    for (int t = 0; t < 6; t++) begin
      fill_random();
      set_mode(1, 1, 1, 299);
      repeat (950) @(posedge clk);
      set_mode(0, 1, 1, 299);
      repeat (4) @(posedge clk);
    end

    // overrun with skip=1: starts stay on rollovers
    fill_lit();
    ready_pct = 50;
    starts = 0;
    set_mode(1, 1, 1, 49);
    repeat (1500) @(posedge clk);
    check(starts >= 3, "R9", "passes started under overrun", starts, 3);
    set_mode(0, 1, 1, 49);
    repeat (4) @(posedge clk);

    // overrun with skip=0: back-to-back passes
    ready_pct = 100;
    align_chk = 0;
    b2b_chk = 1;
    starts = 0;
    set_mode(1, 1, 0, 49);
    repeat (1200) @(posedge clk);
    b2b_chk = 0;
    check(starts >= 6, "R10", "back-to-back passes", starts, 6);
    set_mode(0, 1, 0, 49);
    repeat (4) @(posedge clk);

    // master enable low keeps the block idle, then it starts on a rollover
    align_chk = 1;
    starts = 0;
    set_mode(1, 0, 1, 49);
    repeat (300) @(posedge clk);
    check(starts == 0, "R1", "no pass while disabled", starts, 0);
    set_mode(1, 1, 1, 49);
    repeat (400) @(posedge clk);
    check(starts >= 2, "R8", "passes after enable", starts, 2);

    // stop partway through a pass, then restart
    ready_pct = 40;
    repeat (90) @(posedge clk);
    set_mode(0, 1, 1, 49);
    repeat (3) @(posedge clk);
    starts = 0;
    set_mode(1, 1, 1, 49);
    repeat (400) @(posedge clk);
    check(starts >= 2, "R11", "passes after restart", starts, 2);
    set_mode(0, 0, 1, 49);
    repeat (4) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule